// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of a single DMA channel. A processor reaches it over a simple request bus. Each request carries a 4-bit register slot number, a size code for a 16-bit or 32-bit access, and write data. One cycle later the block returns a response with read data and an error indication. The slots hold the pointers, counts, strides, configuration, interrupt status and peripheral routing that the channel's address generator and descriptor fetcher consume. Those engines sit outside this block.

The block talks to the engines through a few signals. A write to the configuration slot starts the channel when its enable bit is set and stops it when that bit is clear. Either write pulses a one-cycle start or stop strobe. The engines report back through done and error pulses, and through a load strobe that refreshes the current-descriptor, current-address and current-count slots. While the channel runs, the programming slots are locked. Writes to them are acknowledged without error but change nothing. Interrupt status flags are cleared by writing ones to them.

Top module: `dmaChanRegs`

## Requirements
- R1: After reset, the response and strobe outputs are low, the run, done and error flags are clear, and every slot reads as zero. The peripheral routing slot is the exception: it holds the `PMAP_DEFAULT` parameter.
- R2: Each request (`busValid` high) produces `respValid` high in the next cycle, with read data sampled in that same cycle. Size code 2'b10 is a 32-bit access and 2'b01 is a 16-bit access. The 16-bit slots (4 X count, 5 X stride, 6 Y count, 7 Y stride, 12 current X count, 14 current Y count) store the low half of any write. A 32-bit read returns the count slots zero-extended and the stride slots sign-extended.
- R3: The 32-bit slots are 0 next-descriptor pointer, 1 start address, 8 current-descriptor pointer and 9 current address. A 16-bit write to one of them replaces only bits 15:0 and keeps bits 31:16. Any 16-bit read returns bits 15:0 with the upper half zero.
- R4: A request with size code 2'b00 or 2'b11 returns `respErr` with `respErrCode` 1 and changes no state. This holds even when the slot is reserved.
- R5: A legal-size request to reserved slot 3, 13 or 15 returns `respErr` with `respErrCode` 2. It changes no state, and read data is zero.
- R6: While the run flag is set, writes to slots 0, 1, 4 to 9, 11, 12 and 14 complete without error and leave the slot unchanged. Once the channel is stopped, the same writes take effect again.
- R7: A write to the routing slot 11 keeps the stored value of bit `CLASS_BIT` and takes all other bits of the low half from the write data.
- R8: A write to configuration slot 2 is accepted even while running, and the slot stores bits 15:0. If bit 0 is 1, the run flag becomes set and `chanStart` pulses for one cycle. If bit 0 is 0, the run flag clears and `chanStop` pulses for one cycle.
- R9: The status slot 10 reads done at bit 0, error at bit 1 and run at bit 3. Writing 1 to bit 0 or bit 1 clears that flag. Writing 0 has no effect, and writes never change the run bit.
- R10: `engDone` sets the done flag and clears the run flag. `engErr` sets the error flag. A set from the engines wins over a same-cycle write-one clear.
- R11: `engLoad` copies the engine's current descriptor pointer, address and X/Y counts into slots 8, 9, 12 and 14, whatever the run flag is.
- R12: The outputs `nextDescOut`, `startAddrOut`, `cfgOut`, `xCountOut`, `xModifyOut`, `yCountOut`, `yModifyOut` and `pmapOut` always show the stored contents of their slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSlot | input | 4 | Register slot number |
| busSize | input | 2 | 2'b01 half word, 2'b10 word, others illegal |
| busWdata | input | DATA_W | Write data |
| respValid | output | 1 | Response for last cycle's request |
| respErr | output | 1 | Response carries an error |
| respErrCode | output | 2 | 0 none, 1 bad size, 2 reserved slot |
| respRdata | output | DATA_W | Read data |
| chanStart | output | 1 | One-cycle start strobe to the engines |
| chanStop | output | 1 | One-cycle stop strobe to the engines |
| runFlag | output | 1 | Channel running |
| doneFlag | output | 1 | Done status flag |
| errFlag | output | 1 | Error status flag |
| engDone | input | 1 | Engine finished the transfer |
| engErr | input | 1 | Engine detected an error |
| engLoad | input | 1 | Engine refreshes the current-state slots |
| engCurrDesc | input | DATA_W | Current-descriptor pointer from the engine |
| engCurrAddr | input | DATA_W | Current address from the engine |
| engCurrX | input | DATA_W/2 | Current X count from the engine |
| engCurrY | input | DATA_W/2 | Current Y count from the engine |
| nextDescOut | output | DATA_W | Next-descriptor pointer slot |
| startAddrOut | output | DATA_W | Start address slot |
| cfgOut | output | DATA_W/2 | Configuration slot |
| xCountOut | output | DATA_W/2 | X count slot |
| xModifyOut | output | DATA_W/2 | X stride slot (signed) |
| yCountOut | output | DATA_W/2 | Y count slot |
| yModifyOut | output | DATA_W/2 | Y stride slot (signed) |
| pmapOut | output | DATA_W/2 | Peripheral routing slot |

## Verification
The properties assume that `busSlot`, `busSize`, `busWrite` and `busWdata` are known whenever `busValid` is high. They also assume that the engines never write the start-address slot, so a locked write to it must leave that output stable. The done property excludes a configuration write in the same cycle, because that write decides the run flag. The stimulus drives every input at the falling clock edge and holds idle inputs at zero. It issues at most one request per cycle and raises engine pulses together with a bus request only in the single case meant to test the set-over-clear priority.

// File: rtl/dmaChanRegsPkg.sv
package dmaChanRegsPkg;

  localparam int SLOTS = 16;

  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_SIZE = 2'd1;
  localparam logic [1:0] ERR_SLOT = 2'd2;

  localparam int CFG_EN_BIT   = 0;
  localparam int IRQ_DONE_BIT = 0;
  localparam int IRQ_ERR_BIT  = 1;
  localparam int IRQ_RUN_BIT  = 3;

  typedef enum logic [3:0] {
    SLOT_NEXT_DESC = 4'd0,
    SLOT_START     = 4'd1,
    SLOT_CFG       = 4'd2,
    SLOT_GAP_A     = 4'd3,
    SLOT_XCNT      = 4'd4,
    SLOT_XMOD      = 4'd5,
    SLOT_YCNT      = 4'd6,
    SLOT_YMOD      = 4'd7,
    SLOT_CUR_DESC  = 4'd8,
    SLOT_CUR_ADDR  = 4'd9,
    SLOT_IRQ       = 4'd10,
    SLOT_PMAP      = 4'd11,
    SLOT_CUR_X     = 4'd12,
    SLOT_GAP_B     = 4'd13,
    SLOT_CUR_Y     = 4'd14,
    SLOT_GAP_C     = 4'd15
  } slotE;

  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic [SLOTS-1:0] wrHot;    // accepted write, one-hot by slot
    logic             wide;     // 32-bit access
    logic             rdEn;     // accepted read
    logic             startCh;  // configuration write with enable set
    logic             stopCh;   // configuration write with enable clear
  } strobeT;

  function automatic logic isReserved(input logic [3:0] s);
    return (s == SLOT_GAP_A) || (s == SLOT_GAP_B) || (s == SLOT_GAP_C);
  endfunction

  function automatic logic isLocked(input logic [3:0] s);
    return !(isReserved(s) || (s == SLOT_CFG) || (s == SLOT_IRQ));
  endfunction

  function automatic logic sizeLegal(input logic [1:0] z);
    return (z == SZ_HALF) || (z == SZ_WORD);
  endfunction

endpackage

// File: rtl/dmaChanRegsCtrl.sv
module dmaChanRegsCtrl
  import dmaChanRegsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  logic       busWrite,
  input  logic [3:0] busSlot,
  input  logic [1:0] busSize,
  input  logic       enBit,
  input  logic       runFlag,
  output strobeT     stb,
  output logic       respValid,
  output logic       respErr,
  output logic [1:0] respErrCode
);

  logic       sizeOk;
  logic       gapSlot;
  logic       legal;
  logic       wrOk;
  logic [1:0] errNext;

  always_comb begin
    sizeOk  = sizeLegal(busSize);
    gapSlot = isReserved(busSlot);
    legal   = busValid && sizeOk && !gapSlot;
    wrOk    = legal && busWrite && !(runFlag && isLocked(busSlot));
    // A bad size is reported ahead of a reserved slot.
    if (!sizeOk)      errNext = ERR_SIZE;
    else if (gapSlot) errNext = ERR_SLOT;
    else              errNext = ERR_NONE;
  end

  always_comb begin
    stb = '0;
    for (int i = 0; i < SLOTS; i++) begin
      stb.wrHot[i] = wrOk && (busSlot == 4'(i));
    end
    stb.wide    = (busSize == SZ_WORD);
    stb.rdEn    = legal && !busWrite;
    stb.startCh = wrOk && (busSlot == SLOT_CFG) && enBit;
    stb.stopCh  = wrOk && (busSlot == SLOT_CFG) && !enBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respErr     <= 1'b0;
      respErrCode <= ERR_NONE;
    end else begin
      respValid   <= busValid;
      respErr     <= busValid && (errNext != ERR_NONE);
      respErrCode <= busValid ? errNext : ERR_NONE;
    end
  end

endmodule

// File: rtl/dmaChanRegsData.sv
module dmaChanRegsData
  import dmaChanRegsPkg::*;
#(
  parameter int                    DATA_W       = 32,
  parameter logic [DATA_W/2-1:0]   PMAP_DEFAULT = '0,
  parameter int                    CLASS_BIT    = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                stb,
  input  logic [3:0]            busSlot,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  engDone,
  input  logic                  engErr,
  input  logic                  engLoad,
  input  logic [DATA_W-1:0]     engCurrDesc,
  input  logic [DATA_W-1:0]     engCurrAddr,
  input  logic [DATA_W/2-1:0]   engCurrX,
  input  logic [DATA_W/2-1:0]   engCurrY,
  output logic [DATA_W-1:0]     respRdata,
  output logic                  chanStart,
  output logic                  chanStop,
  output logic                  runFlag,
  output logic                  doneFlag,
  output logic                  errFlag,
  output logic [DATA_W-1:0]     nextDescOut,
  output logic [DATA_W-1:0]     startAddrOut,
  output logic [DATA_W/2-1:0]   cfgOut,
  output logic [DATA_W/2-1:0]   xCountOut,
  output logic [DATA_W/2-1:0]   xModifyOut,
  output logic [DATA_W/2-1:0]   yCountOut,
  output logic [DATA_W/2-1:0]   yModifyOut,
  output logic [DATA_W/2-1:0]   pmapOut
);

  localparam int HALF_W  = DATA_W / 2;
  localparam int N_WIDE  = 4;
  localparam int N_HALF  = 6;
  localparam logic [3:0] WIDE_SLOT [N_WIDE] = '{4'd0, 4'd1, 4'd8, 4'd9};
  localparam logic [N_WIDE-1:0] WIDE_ENG = 4'b1100;
  localparam logic [3:0] HALF_SLOT [N_HALF] = '{4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd14};
  localparam logic [N_HALF-1:0] HALF_ENG = 6'b110000;
  localparam logic [HALF_W-1:0] CLASS_MASK = {{(HALF_W-1){1'b0}}, 1'b1} << CLASS_BIT;

  logic [DATA_W-1:0] wideVal [N_WIDE];
  logic [HALF_W-1:0] halfVal [N_HALF];
  logic [HALF_W-1:0] cfgQ;
  logic [HALF_W-1:0] pmapQ;
  logic              runQ;
  logic              doneQ;
  logic              errQ;
  logic [DATA_W-1:0] rdVal;

  // Pointer and address slots: 32 bits, half-word writes merge.
  for (genvar g = 0; g < N_WIDE; g++) begin : gWide
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] engV;
    assign engV = (g == 3) ? engCurrAddr : engCurrDesc;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (WIDE_ENG[g] && engLoad) begin
        q <= engV;
      end else if (stb.wrHot[WIDE_SLOT[g]]) begin
        q <= stb.wide ? busWdata : {q[DATA_W-1:HALF_W], busWdata[HALF_W-1:0]};
      end
    end
    assign wideVal[g] = q;
  end

  // Count and stride slots: 16 bits.
  for (genvar g = 0; g < N_HALF; g++) begin : gHalf
    logic [HALF_W-1:0] q;
    logic [HALF_W-1:0] engV;
    assign engV = (g == 5) ? engCurrY : engCurrX;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '0;
      end else if (HALF_ENG[g] && engLoad) begin
        q <= engV;
      end else if (stb.wrHot[HALF_SLOT[g]]) begin
        q <= busWdata[HALF_W-1:0];
      end
    end
    assign halfVal[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      pmapQ <= PMAP_DEFAULT;
    end else begin
      if (stb.wrHot[SLOT_CFG]) cfgQ <= busWdata[HALF_W-1:0];
      if (stb.wrHot[SLOT_PMAP]) begin
        pmapQ <= (busWdata[HALF_W-1:0] & ~CLASS_MASK) | (pmapQ & CLASS_MASK);
      end
    end
  end

  // Run, done and error flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      doneQ     <= 1'b0;
      errQ      <= 1'b0;
      chanStart <= 1'b0;
      chanStop  <= 1'b0;
    end else begin
      chanStart <= stb.startCh;
      chanStop  <= stb.stopCh;
      if (stb.startCh)     runQ <= 1'b1;
      else if (stb.stopCh) runQ <= 1'b0;
      else if (engDone)    runQ <= 1'b0;
      if (engDone)                                         doneQ <= 1'b1;
      else if (stb.wrHot[SLOT_IRQ] && busWdata[IRQ_DONE_BIT]) doneQ <= 1'b0;
      if (engErr)                                          errQ <= 1'b1;
      else if (stb.wrHot[SLOT_IRQ] && busWdata[IRQ_ERR_BIT])  errQ <= 1'b0;
    end
  end

  always_comb begin
    rdVal = '0;
    case (busSlot)
      SLOT_NEXT_DESC: rdVal = wideVal[0];
      SLOT_START:     rdVal = wideVal[1];
      SLOT_CUR_DESC:  rdVal = wideVal[2];
      SLOT_CUR_ADDR:  rdVal = wideVal[3];
      SLOT_CFG:       rdVal = {{HALF_W{1'b0}}, cfgQ};
      SLOT_XCNT:      rdVal = {{HALF_W{1'b0}}, halfVal[0]};
      SLOT_XMOD:      rdVal = {{HALF_W{halfVal[1][HALF_W-1]}}, halfVal[1]};
      SLOT_YCNT:      rdVal = {{HALF_W{1'b0}}, halfVal[2]};
      SLOT_YMOD:      rdVal = {{HALF_W{halfVal[3][HALF_W-1]}}, halfVal[3]};
      SLOT_CUR_X:     rdVal = {{HALF_W{1'b0}}, halfVal[4]};
      SLOT_CUR_Y:     rdVal = {{HALF_W{1'b0}}, halfVal[5]};
      SLOT_PMAP:      rdVal = {{HALF_W{1'b0}}, pmapQ};
      SLOT_IRQ: begin
        rdVal[IRQ_DONE_BIT] = doneQ;
        rdVal[IRQ_ERR_BIT]  = errQ;
        rdVal[IRQ_RUN_BIT]  = runQ;
      end
      default:        rdVal = '0;
    endcase
    if (!stb.wide) rdVal[DATA_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          respRdata <= '0;
    else if (stb.rdEn)  respRdata <= rdVal;
    else                respRdata <= '0;
  end

  assign runFlag      = runQ;
  assign doneFlag     = doneQ;
  assign errFlag      = errQ;
  assign nextDescOut  = wideVal[0];
  assign startAddrOut = wideVal[1];
  assign cfgOut       = cfgQ;
  assign xCountOut    = halfVal[0];
  assign xModifyOut   = halfVal[1];
  assign yCountOut    = halfVal[2];
  assign yModifyOut   = halfVal[3];
  assign pmapOut      = pmapQ;

endmodule

// File: rtl/dmaChanRegs.sv
module dmaChanRegs
  import dmaChanRegsPkg::*;
#(
  parameter int                  DATA_W       = 32,
  parameter logic [DATA_W/2-1:0] PMAP_DEFAULT = 16'h0045,
  parameter int                  CLASS_BIT    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [3:0]          busSlot,
  input  logic [1:0]          busSize,
  input  logic [DATA_W-1:0]   busWdata,
  output logic                respValid,
  output logic                respErr,
  output logic [1:0]          respErrCode,
  output logic [DATA_W-1:0]   respRdata,
  output logic                chanStart,
  output logic                chanStop,
  output logic                runFlag,
  output logic                doneFlag,
  output logic                errFlag,
  input  logic                engDone,
  input  logic                engErr,
  input  logic                engLoad,
  input  logic [DATA_W-1:0]   engCurrDesc,
  input  logic [DATA_W-1:0]   engCurrAddr,
  input  logic [DATA_W/2-1:0] engCurrX,
  input  logic [DATA_W/2-1:0] engCurrY,
  output logic [DATA_W-1:0]   nextDescOut,
  output logic [DATA_W-1:0]   startAddrOut,
  output logic [DATA_W/2-1:0] cfgOut,
  output logic [DATA_W/2-1:0] xCountOut,
  output logic [DATA_W/2-1:0] xModifyOut,
  output logic [DATA_W/2-1:0] yCountOut,
  output logic [DATA_W/2-1:0] yModifyOut,
  output logic [DATA_W/2-1:0] pmapOut
);

  strobeT stb;

  dmaChanRegsCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .busValid    (busValid),
    .busWrite    (busWrite),
    .busSlot     (busSlot),
    .busSize     (busSize),
    .enBit       (busWdata[CFG_EN_BIT]),
    .runFlag     (runFlag),
    .stb         (stb),
    .respValid   (respValid),
    .respErr     (respErr),
    .respErrCode (respErrCode)
  );

  dmaChanRegsData #(
    .DATA_W       (DATA_W),
    .PMAP_DEFAULT (PMAP_DEFAULT),
    .CLASS_BIT    (CLASS_BIT)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .busSlot      (busSlot),
    .busWdata     (busWdata),
    .engDone      (engDone),
    .engErr       (engErr),
    .engLoad      (engLoad),
    .engCurrDesc  (engCurrDesc),
    .engCurrAddr  (engCurrAddr),
    .engCurrX     (engCurrX),
    .engCurrY     (engCurrY),
    .respRdata    (respRdata),
    .chanStart    (chanStart),
    .chanStop     (chanStop),
    .runFlag      (runFlag),
    .doneFlag     (doneFlag),
    .errFlag      (errFlag),
    .nextDescOut  (nextDescOut),
    .startAddrOut (startAddrOut),
    .cfgOut       (cfgOut),
    .xCountOut    (xCountOut),
    .xModifyOut   (xModifyOut),
    .yCountOut    (yCountOut),
    .yModifyOut   (yModifyOut),
    .pmapOut      (pmapOut)
  );

endmodule

// File: rtl/dmaChanRegsChk.sv
module dmaChanRegsChk
  import dmaChanRegsPkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [3:0]        busSlot,
  input logic [1:0]        busSize,
  input logic [DATA_W-1:0] busWdata,
  input logic              respValid,
  input logic              respErr,
  input logic [1:0]        respErrCode,
  input logic              chanStart,
  input logic              chanStop,
  input logic              runFlag,
  input logic              doneFlag,
  input logic              engDone,
  input logic [DATA_W-1:0] startAddrOut
);

  logic cfgWr;
  assign cfgWr = busValid && busWrite && sizeLegal(busSize) && (busSlot == SLOT_CFG);

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> respValid);

  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !respValid && !respErr);

  a_r4_size_first: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !sizeLegal(busSize) |=> respErr && (respErrCode == ERR_SIZE));

  a_r5_gap_slot: assert property (@(posedge clk) disable iff (!rstN)
    busValid && sizeLegal(busSize) && isReserved(busSlot)
      |=> respErr && (respErrCode == ERR_SLOT));

  a_r6_locked_start: assert property (@(posedge clk) disable iff (!rstN)
    runFlag && busValid && busWrite && (busSlot == SLOT_START) |=> $stable(startAddrOut));

  a_r8_start: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr && busWdata[CFG_EN_BIT] |=> runFlag && chanStart);

  a_r8_stop: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr && !busWdata[CFG_EN_BIT] |=> !runFlag && chanStop);

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(chanStart && chanStop));

  a_r9_w1c_done: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && sizeLegal(busSize) && (busSlot == SLOT_IRQ)
      && busWdata[IRQ_DONE_BIT] && !engDone |=> !doneFlag);

  a_r10_done: assert property (@(posedge clk) disable iff (!rstN)
    engDone && !cfgWr |=> !runFlag && doneFlag);

endmodule

bind dmaChanRegs dmaChanRegsChk #(.DATA_W(DATA_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .busValid     (busValid),
  .busWrite     (busWrite),
  .busSlot      (busSlot),
  .busSize      (busSize),
  .busWdata     (busWdata),
  .respValid    (respValid),
  .respErr      (respErr),
  .respErrCode  (respErrCode),
  .chanStart    (chanStart),
  .chanStop     (chanStop),
  .runFlag      (runFlag),
  .doneFlag     (doneFlag),
  .engDone      (engDone),
  .startAddrOut (startAddrOut)
);

// File: tb/sim_dmaChanRegs.sv
`timescale 1ns/1ps
module sim_dmaChanRegs;

  localparam int          DW   = 32;
  localparam logic [15:0] PDEF = 16'h0045;
  localparam int          CB   = 6;
  localparam logic [1:0]  ZH   = 2'b01;
  localparam logic [1:0]  ZW   = 2'b10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [3:0]  busSlot = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic        respValid, respErr;
  logic [1:0]  respErrCode;
  logic [31:0] respRdata;
  logic        chanStart, chanStop, runFlag, doneFlag, errFlag;
  logic        engDone = 1'b0, engErr = 1'b0, engLoad = 1'b0;
  logic [31:0] engCurrDesc = '0, engCurrAddr = '0;
  logic [15:0] engCurrX = '0, engCurrY = '0;
  logic [31:0] nextDescOut, startAddrOut;
  logic [15:0] cfgOut, xCountOut, xModifyOut, yCountOut, yModifyOut, pmapOut;

  dmaChanRegs #(.DATA_W(DW), .PMAP_DEFAULT(PDEF), .CLASS_BIT(CB)) u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busSlot(busSlot), .busSize(busSize), .busWdata(busWdata),
    .respValid(respValid), .respErr(respErr), .respErrCode(respErrCode),
    .respRdata(respRdata), .chanStart(chanStart), .chanStop(chanStop),
    .runFlag(runFlag), .doneFlag(doneFlag), .errFlag(errFlag),
    .engDone(engDone), .engErr(engErr), .engLoad(engLoad),
    .engCurrDesc(engCurrDesc), .engCurrAddr(engCurrAddr),
    .engCurrX(engCurrX), .engCurrY(engCurrY),
    .nextDescOut(nextDescOut), .startAddrOut(startAddrOut), .cfgOut(cfgOut),
    .xCountOut(xCountOut), .xModifyOut(xModifyOut), .yCountOut(yCountOut),
    .yModifyOut(yModifyOut), .pmapOut(pmapOut)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  logic [31:0] mReg [16];
  bit mRun, mDone, mErr;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic bit isWide(input int s);
    return s == 0 || s == 1 || s == 8 || s == 9;
  endfunction
  function automatic bit gapSlot(input int s);
    return s == 3 || s == 13 || s == 15;
  endfunction
  function automatic bit lockSlot(input int s);
    return !(gapSlot(s) || s == 2 || s == 10);
  endfunction
  function automatic bit goodSize(input logic [1:0] z);
    return z == ZH || z == ZW;
  endfunction

  function automatic logic [31:0] expRead(input int s, input logic [1:0] z);
    logic [31:0] v;
    if (gapSlot(s) || !goodSize(z)) return 32'h0;
    if (isWide(s))                 v = mReg[s];
    else if (s == 5 || s == 7)     v = {{16{mReg[s][15]}}, mReg[s][15:0]};
    else if (s == 10)              v = {28'h0, mRun, 1'b0, mErr, mDone};
    else                           v = {16'h0, mReg[s][15:0]};
    if (z == ZH) v[31:16] = 16'h0;
    return v;
  endfunction

  task automatic modelWrite(input int s, input logic [1:0] z, input logic [31:0] d);
    if (!goodSize(z) || gapSlot(s)) return;
    if (mRun && lockSlot(s)) return;
    if (isWide(s)) mReg[s] = (z == ZW) ? d : {mReg[s][31:16], d[15:0]};
    else if (s == 11) mReg[s] = {16'h0, (d[15:0] & ~(16'h1 << CB)) | (mReg[s][15:0] & (16'h1 << CB))};
    else if (s == 10) begin
      if (d[0]) mDone = 0;
      if (d[1]) mErr = 0;
    end else begin
      mReg[s] = {16'h0, d[15:0]};
      if (s == 2) mRun = d[0];
    end
  endtask

  task automatic checkFlags(input string req);
    check(req, "runFlag", {31'h0, runFlag}, {31'h0, mRun});
    check(req, "doneFlag", {31'h0, doneFlag}, {31'h0, mDone});
    check(req, "errFlag", {31'h0, errFlag}, {31'h0, mErr});
  endtask

  task automatic checkOuts(input string req);
    check(req, "nextDescOut", nextDescOut, mReg[0]);
    check(req, "startAddrOut", startAddrOut, mReg[1]);
    check(req, "cfgOut", {16'h0, cfgOut}, {16'h0, mReg[2][15:0]});
    check(req, "xCountOut", {16'h0, xCountOut}, {16'h0, mReg[4][15:0]});
    check(req, "xModifyOut", {16'h0, xModifyOut}, {16'h0, mReg[5][15:0]});
    check(req, "yCountOut", {16'h0, yCountOut}, {16'h0, mReg[6][15:0]});
    check(req, "yModifyOut", {16'h0, yModifyOut}, {16'h0, mReg[7][15:0]});
    check(req, "pmapOut", {16'h0, pmapOut}, {16'h0, mReg[11][15:0]});
  endtask

  // One bus request; response sampled at the falling edge after the capturing edge.
  task automatic busOp(input bit wr, input int s, input logic [1:0] z,
                       input logic [31:0] d, input string req);
    logic [1:0]  code;
    logic [31:0] expRd;
    bit          expSt, expSp;
    code  = !goodSize(z) ? 2'd1 : (gapSlot(s) ? 2'd2 : 2'd0);
    expRd = (!wr && code == 2'd0) ? expRead(s, z) : 32'h0;
    expSt = wr && code == 2'd0 && s == 2 && d[0];
    expSp = wr && code == 2'd0 && s == 2 && !d[0];
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busSlot = 4'(s); busSize = z; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busWdata = '0;
    if (wr) modelWrite(s, z, d);
    check(req, "respValid", {31'h0, respValid}, 32'h1);
    check(req, "respErr", {31'h0, respErr}, {31'h0, code != 2'd0});
    check(req, "respErrCode", {30'h0, respErrCode}, {30'h0, code});
    if (!wr) check(req, "respRdata", respRdata, expRd);
    check(req, "chanStart", {31'h0, chanStart}, {31'h0, expSt});
    check(req, "chanStop", {31'h0, chanStop}, {31'h0, expSp});
    checkFlags(req);
  endtask

  task automatic engOp(input bit dn, input bit er, input bit ld, input logic [31:0] desc,
                       input logic [31:0] addr, input logic [15:0] cx, input logic [15:0] cy,
                       input string req);
    @(negedge clk);
    engDone = dn; engErr = er; engLoad = ld;
    engCurrDesc = desc; engCurrAddr = addr; engCurrX = cx; engCurrY = cy;
    @(negedge clk);
    engDone = 0; engErr = 0; engLoad = 0;
    if (ld) begin
      mReg[8] = desc; mReg[9] = addr; mReg[12] = {16'h0, cx}; mReg[14] = {16'h0, cy};
    end
    if (er) mErr = 1;
    if (dn) begin mDone = 1; mRun = 0; end
    checkFlags(req);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before the run ended");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) mReg[i] = 32'h0;
    mReg[11] = {16'h0, PDEF};
    mRun = 0; mDone = 0; mErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state at the ports
    check("R1", "respValid", {31'h0, respValid}, 32'h0);
    check("R1", "chanStart", {31'h0, chanStart}, 32'h0);
    check("R1", "chanStop", {31'h0, chanStop}, 32'h0);
    checkFlags("R1");
    checkOuts("R1");
    for (int s = 0; s < 16; s++) busOp(0, s, ZW, 32'h0, gapSlot(s) ? "R5" : "R1");

    // R2 R3 R7: write sweep while idle, both sizes, read back both sizes
    for (int s = 0; s < 16; s++) begin
      if (s == 2 || s == 10) continue;
      for (int k = 1; k <= 2; k++) begin
        logic [31:0] d;
        d = (32'h9E37_79B9 * (s + 1)) ^ (32'h0F0F_8421 * k);
        busOp(1, s, 2'(k), d, gapSlot(s) ? "R5" : (s == 11 ? "R7" : "R2"));
        busOp(0, s, ZW, 32'h0, isWide(s) ? "R3" : "R2");
        busOp(0, s, ZH, 32'h0, "R3");
      end
    end
    busOp(1, 5, ZH, 32'h0000_8003, "R2");
    busOp(0, 5, ZW, 32'h0, "R2");
    busOp(1, 7, ZW, 32'h1234_FFFE, "R2");
    busOp(0, 7, ZW, 32'h0, "R2");
    busOp(1, 4, ZW, 32'hABCD_9001, "R2");
    busOp(0, 4, ZW, 32'h0, "R2");
    busOp(1, 1, ZW, 32'hCAFE_0000, "R3");
    busOp(1, 1, ZH, 32'h5555_1234, "R3");
    busOp(0, 1, ZW, 32'h0, "R3");
    busOp(1, 11, ZH, 32'h0000_0000, "R7");
    busOp(0, 11, ZW, 32'h0, "R7");
    busOp(1, 11, ZH, 32'h0000_FFBF, "R7");
    busOp(0, 11, ZW, 32'h0, "R7");
    checkOuts("R12");

    // R4: illegal sizes on every slot, reserved ones included
    for (int s = 0; s < 16; s++) begin
      busOp(1, s, 2'b00, 32'hFFFF_FFFF, "R4");
      busOp(1, s, 2'b11, 32'h0000_0001, "R4");
      busOp(0, s, 2'b11, 32'h0, "R4");
    end
    for (int s = 0; s < 16; s++) busOp(0, s, ZW, 32'h0, "R4");
    checkFlags("R4");
    checkOuts("R4");

    // R8: start the channel
    busOp(1, 2, ZH, 32'h0000_0A1B, "R8");
    @(negedge clk);
    check("R8", "chanStart one cycle", {31'h0, chanStart}, 32'h0);
    checkOuts("R8");

    // R6: locked slots while running
    for (int s = 0; s < 16; s++) begin
      if (!lockSlot(s)) continue;
      busOp(1, s, ZW, ~mReg[s], "R6");
      busOp(0, s, ZW, 32'h0, "R6");
    end
    checkOuts("R6");

    // R11: engine refresh of current-state slots while running
    engOp(0, 0, 1, 32'h1000_0040, 32'h2000_0104, 16'h0033, 16'h0007, "R11");
    for (int s = 8; s <= 14; s++) if (s != 10 && s != 11 && s != 13) busOp(0, s, ZW, 32'h0, "R11");

    // R8: configuration accepted while running
    busOp(1, 2, ZW, 32'h7777_0C35, "R8");
    checkOuts("R8");

    // R10: engine error then done
    engOp(0, 1, 0, 32'h0, 32'h0, 16'h0, 16'h0, "R10");
    engOp(1, 0, 0, 32'h0, 32'h0, 16'h0, 16'h0, "R10");
    busOp(0, 10, ZW, 32'h0, "R10");

    // R9: write-one-to-clear behaviour, run bit read-only
    busOp(1, 10, ZH, 32'h0000_0000, "R9");
    busOp(1, 10, ZH, 32'h0000_0001, "R9");
    busOp(0, 10, ZH, 32'h0, "R9");
    busOp(1, 2, ZH, 32'h0000_0001, "R9");
    engOp(0, 1, 0, 32'h0, 32'h0, 16'h0, 16'h0, "R9");
    busOp(1, 10, ZW, 32'hFFFF_FFF7, "R9");
    busOp(1, 10, ZW, 32'hFFFF_FFFF, "R9");
    busOp(0, 10, ZW, 32'h0, "R9");

    // R10: engine done beats a same-cycle clear
    @(negedge clk);
    busValid = 1; busWrite = 1; busSlot = 4'd10; busSize = ZH; busWdata = 32'h1;
    engDone = 1;
    @(negedge clk);
    busValid = 0; busWrite = 0; busWdata = '0; engDone = 0;
    mDone = 1; mRun = 0;
    checkFlags("R10");

    // R8: start then stop
    busOp(1, 2, ZH, 32'h0000_0001, "R8");
    busOp(1, 2, ZH, 32'h0000_0A1A, "R8");
    @(negedge clk);
    check("R8", "chanStop one cycle", {31'h0, chanStop}, 32'h0);

    // R6: unlocked again once stopped
    busOp(1, 1, ZW, 32'h0BAD_F00D, "R6");
    busOp(1, 6, ZW, 32'h0000_00FF, "R6");
    checkOuts("R12");

    finishRun();
  end

endmodule